// File: doc/BRIEF.md
# Cycle-Count Timing Wheel

This block holds event identifiers that are due a given number of cycles in the future and hands them back, one per clock, once the elapsed cycle count has moved past their due slot. The wheel is a circular array of slots indexed modulo its size. Each slot keeps a short stack of identifiers. A scheduled event goes into the slot found by adding its delay to the wheel's current position.

Elapsed time is the sum of five separate cycle counters, which the owner presents on the counter inputs. When the owner raises the update strobe, the block takes the new position as that sum modulo the wheel size. It then walks forward from the old position to the new one, wrapping past the last slot when needed, and releases every event it finds on the way. Several cycles can pass between updates, so one update may cover many slots. While the walk is in progress the block raises `busy` and accepts neither schedules nor updates. The owner keeps a count of outstanding events from the `pending` output.

Top module: `event_wheel`

## Requirements
- R1: After reset, `busy`, `fireValid`, `overflow` and `pending` are all 0.
- R2: An accepted schedule with delay d places its identifier in slot (position + d) mod 2^IDX_W. The event fires during the first accepted update whose walk, stepping up one slot at a time from the old position to the new one, reaches that slot. An update that stops short of the slot does not fire it.
- R3: A schedule aimed at a slot that already holds SLOT_DEPTH identifiers is dropped. `overflow` is then 1 for exactly the following cycle, and `pending` does not change.
- R4: Identifiers sharing a slot fire newest first.
- R5: `pending` rises by one on each stored schedule and falls by one in the cycle each identifier appears on `fireValid`.
- R6: While `pending` is 0, an accepted schedule or update first sets the position to the current counter sum mod 2^IDX_W. An update on an empty wheel fires nothing and leaves `busy` low.
- R7: If the new position is below the old one, the walk covers the old position up to the last slot, then slot 0 up to the new position.
- R8: When one update passes several slots, their events come out in walk order: a slot's events all leave before the next slot's.
- R9: At most one identifier appears per cycle, and `fireValid` is only ever 1 while `busy` is 1.
- R10: While `busy` is 1, `schedValid` and `updateValid` are ignored.
- R11: A schedule with delay 0 is ignored.
- R12: The elapsed count is the sum of the five `typeCycles` fields, computed modulo 2^CNT_W.
- R13: An update whose new position equals the old position fires nothing.
- R14: When a schedule and an update are accepted in the same cycle on a non-empty wheel, the schedule is placed relative to the old position. The walk started by that update can then fire the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| schedValid | input | 1 | Schedule request, taken when `busy` is 0 |
| schedDelay | input | IDX_W | Delay in slots, 1 to 2^IDX_W-1 |
| schedId | input | ID_W | Identifier to store |
| updateValid | input | 1 | Advance the position to the current counter sum |
| typeCycles | input | NUM_CTR x CNT_W | Per-type cycle counters, summed to form elapsed time |
| busy | output | 1 | Walk in progress; inputs are ignored |
| fireValid | output | 1 | `fireId` carries a released identifier |
| fireId | output | ID_W | Released identifier |
| pending | output | clog2(2^IDX_W*SLOT_DEPTH+1) | Number of stored events |
| overflow | output | 1 | One-cycle pulse: the last schedule was dropped |

## Verification
A schedule and an update can be accepted in the same idle cycle. The design must place the new event relative to the position held before that update, not the one being moved to. The bench provokes this by scheduling one event and then issuing a combined schedule and update whose walk spans both target slots. It passes only if both identifiers fire in slot order and `pending` returns to zero. Had the event been placed from the new position, it would land beyond the walk and remain pending.

// File: rtl/event_wheel_pkg.sv
package event_wheel_pkg;

  // strobes from the sequencer to the slot storage
  typedef struct packed {
    logic push;        // store the incoming identifier
    logic loadRef;     // copy counter-derived position (empty wheel)
    logic startDrain;  // open a walk from old to new position
    logic pop;         // release the top identifier of the current slot
    logic step;        // move to the next slot in the walk
  } wheelStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } wheelState_t;

endpackage

// File: rtl/event_wheel_ctrl.sv
module event_wheel_ctrl
  import event_wheel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         schedValid,
  input  logic         schedOk,
  input  logic         updateValid,
  input  logic         wheelEmpty,
  input  logic         sameSlot,
  input  logic         curEmpty,
  input  logic         atEnd,
  output wheelStrobe_t strobe,
  output logic         busy
);

  wheelState_t state, nextState;
  logic        schedTaken;

  assign schedTaken = schedValid && schedOk;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        strobe.push = schedTaken;
        if (wheelEmpty) begin
          strobe.loadRef = schedTaken || updateValid;
        end else if (updateValid && !sameSlot) begin
          strobe.startDrain = 1'b1;
          nextState         = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!curEmpty)   strobe.pop  = 1'b1;
        else if (!atEnd) strobe.step = 1'b1;
        else             nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state == ST_DRAIN);

endmodule

// File: rtl/event_wheel_store.sv
module event_wheel_store
  import event_wheel_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int SLOT_DEPTH = 4,
  parameter int ID_W       = 8,
  parameter int CNT_W      = 16,
  parameter int NUM_CTR    = 5,
  parameter int PEND_W     = $clog2((1 << IDX_W) * SLOT_DEPTH + 1)
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  wheelStrobe_t                  strobe,
  input  logic [IDX_W-1:0]              schedDelay,
  input  logic [ID_W-1:0]               schedId,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] typeCycles,
  output logic                          schedOk,
  output logic                          wheelEmpty,
  output logic                          sameSlot,
  output logic                          curEmpty,
  output logic                          atEnd,
  output logic                          fireValid,
  output logic [ID_W-1:0]               fireId,
  output logic [PEND_W-1:0]             pending,
  output logic                          overflow
);

  localparam int SLOTS  = 1 << IDX_W;
  localparam int FILL_W = $clog2(SLOT_DEPTH + 1);
  localparam int DIX_W  = (SLOT_DEPTH > 1) ? $clog2(SLOT_DEPTH) : 1;

  logic [CNT_W-1:0]  elapsed;
  logic [IDX_W-1:0]  newNow, nowReg, refNow, target, curPtr, endPtr;
  logic [FILL_W-1:0] fillV [SLOTS];
  logic [ID_W-1:0]   topV  [SLOTS];
  logic              fullV [SLOTS];
  logic              targetFull;

  always_comb begin
    elapsed = '0;
    for (int i = 0; i < NUM_CTR; i++) elapsed = elapsed + typeCycles[i];
  end

  assign newNow     = elapsed[IDX_W-1:0];
  assign wheelEmpty = (pending == '0);
  assign refNow     = wheelEmpty ? newNow : nowReg;
  assign target     = refNow + schedDelay;
  assign targetFull = fullV[target];
  assign schedOk    = (schedDelay != '0);
  assign sameSlot   = (newNow == nowReg);
  assign curEmpty   = (fillV[curPtr] == '0);
  assign atEnd      = (curPtr == endPtr);

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic [ID_W-1:0]   entry [SLOT_DEPTH];
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] topIdx;
    logic              pushHere, popHere;

    assign topIdx   = fill - FILL_W'(1);
    assign pushHere = strobe.push && (target == IDX_W'(g)) && !fullV[g];
    assign popHere  = strobe.pop && (curPtr == IDX_W'(g));
    assign fillV[g] = fill;
    assign fullV[g] = (fill == FILL_W'(SLOT_DEPTH));
    assign topV[g]  = entry[topIdx[DIX_W-1:0]];

    always_ff @(posedge clk) begin
      if (!rstN)         fill <= '0;
      else if (pushHere) fill <= fill + FILL_W'(1);
      else if (popHere)  fill <= fill - FILL_W'(1);
    end

    always_ff @(posedge clk) begin
      if (pushHere) entry[fill[DIX_W-1:0]] <= schedId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowReg    <= '0;
      curPtr    <= '0;
      endPtr    <= '0;
      pending   <= '0;
      fireValid <= 1'b0;
      fireId    <= '0;
      overflow  <= 1'b0;
    end else begin
      fireValid <= 1'b0;
      overflow  <= 1'b0;
      if (strobe.loadRef) nowReg <= newNow;
      if (strobe.startDrain) begin
        nowReg <= newNow;
        curPtr <= nowReg;
        endPtr <= newNow;
      end
      if (strobe.step) curPtr <= curPtr + IDX_W'(1);
      if (strobe.push) begin
        if (targetFull) overflow <= 1'b1;
        else            pending  <= pending + PEND_W'(1);
      end
      if (strobe.pop) begin
        fireValid <= 1'b1;
        fireId    <= topV[curPtr];
        pending   <= pending - PEND_W'(1);
      end
    end
  end

endmodule

// File: rtl/event_wheel.sv
module event_wheel
  import event_wheel_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int SLOT_DEPTH = 4,
  parameter int ID_W       = 8,
  parameter int CNT_W      = 16,
  parameter int NUM_CTR    = 5
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          schedValid,
  input  logic [IDX_W-1:0]              schedDelay,
  input  logic [ID_W-1:0]               schedId,
  input  logic                          updateValid,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] typeCycles,
  output logic                          busy,
  output logic                          fireValid,
  output logic [ID_W-1:0]               fireId,
  output logic [$clog2((1 << IDX_W) * SLOT_DEPTH + 1)-1:0] pending,
  output logic                          overflow
);

  localparam int PEND_W = $clog2((1 << IDX_W) * SLOT_DEPTH + 1);

  wheelStrobe_t strobe;
  logic schedOk, wheelEmpty, sameSlot, curEmpty, atEnd;

  event_wheel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .schedValid (schedValid),
    .schedOk    (schedOk),
    .updateValid(updateValid),
    .wheelEmpty (wheelEmpty),
    .sameSlot   (sameSlot),
    .curEmpty   (curEmpty),
    .atEnd      (atEnd),
    .strobe     (strobe),
    .busy       (busy)
  );

  event_wheel_store #(
    .IDX_W     (IDX_W),
    .SLOT_DEPTH(SLOT_DEPTH),
    .ID_W      (ID_W),
    .CNT_W     (CNT_W),
    .NUM_CTR   (NUM_CTR),
    .PEND_W    (PEND_W)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .schedDelay(schedDelay),
    .schedId   (schedId),
    .typeCycles(typeCycles),
    .schedOk   (schedOk),
    .wheelEmpty(wheelEmpty),
    .sameSlot  (sameSlot),
    .curEmpty  (curEmpty),
    .atEnd     (atEnd),
    .fireValid (fireValid),
    .fireId    (fireId),
    .pending   (pending),
    .overflow  (overflow)
  );

endmodule

// File: rtl/event_wheel_checker.sv
module event_wheel_checker #(
  parameter int PW = 7
)(
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          fireValid,
  input logic [PW-1:0] pending,
  input logic          overflow
);

  // R9: released identifiers only appear during a walk
  p_fire_in_walk_r9: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> busy);

  // R5: each release takes exactly one from the outstanding count
  p_fire_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> (pending == $past(pending) - PW'(1)));

  // R5: the count never moves by more than one per cycle
  p_pend_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pending == $past(pending)) ||
    (pending == $past(pending) + PW'(1)) ||
    (pending == $past(pending) - PW'(1)));

  // R3: a dropped schedule leaves the count alone
  p_no_overflow_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> $stable(pending));

  // R10: no schedule is stored while a walk is running
  p_busy_no_store_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> (pending <= $past(pending)));

  // R3: overflow never coincides with a release
  p_overflow_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !fireValid);

endmodule

bind event_wheel event_wheel_checker #(.PW(PEND_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .fireValid(fireValid),
  .pending  (pending),
  .overflow (overflow)
);

// File: tb/event_wheel_test.sv
module event_wheel_test;

  localparam int IDX_W = 4;
  localparam int DEPTH = 4;
  localparam int ID_W  = 8;
  localparam int CNT_W = 16;
  localparam int NCTR  = 5;
  localparam int PW    = $clog2((1 << IDX_W) * DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic schedValid = 1'b0;
  logic [IDX_W-1:0] schedDelay = '0;
  logic [ID_W-1:0] schedId = '0;
  logic updateValid = 1'b0;
  logic [NCTR-1:0][CNT_W-1:0] typeCycles = '0;
  logic busy, fireValid, overflow;
  logic [ID_W-1:0] fireId;
  logic [PW-1:0] pending;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  event_wheel uut (
    .clk(clk), .rstN(rstN), .schedValid(schedValid), .schedDelay(schedDelay),
    .schedId(schedId), .updateValid(updateValid), .typeCycles(typeCycles),
    .busy(busy), .fireValid(fireValid), .fireId(fireId), .pending(pending),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectFire(input int id, input string tag);
    expQ.push_back(id);
    tagQ.push_back(tag);
  endtask

  // monitor: compare each released identifier against the scoreboard
  always @(negedge clk) begin
    if (rstN && fireValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected fire", int'(fireId), -1);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(fireId) == e, t, int'(fireId), e);
      end
    end
  end

  // R12: spread a total unevenly over the five counters
  task automatic setTime(input int total);
    int p1, p2, p3, p4;
    p1 = total / 3; p2 = total / 5; p3 = total / 7; p4 = total / 11;
    typeCycles[1] = CNT_W'(p1);
    typeCycles[2] = CNT_W'(p2);
    typeCycles[3] = CNT_W'(p3);
    typeCycles[4] = CNT_W'(p4);
    typeCycles[0] = CNT_W'(total - p1 - p2 - p3 - p4);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic sched(input int d, input int id);
    @(negedge clk);
    schedValid = 1'b1; schedDelay = IDX_W'(d); schedId = ID_W'(id);
    @(negedge clk);
    schedValid = 1'b0;
  endtask

  task automatic update(input int total);
    @(negedge clk);
    setTime(total);
    updateValid = 1'b1;
    @(negedge clk);
    updateValid = 1'b0;
    waitIdle();
  endtask

  task automatic drained(input string tag, input int expPend);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    check(int'(pending) == expPend, tag, int'(pending), expPend);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !fireValid && !overflow && pending == 0, "R1 reset state",
          int'({busy, fireValid, overflow}) + int'(pending), 0);

    // R6: update on empty wheel moves position, nothing fires
    update(5);
    check(!busy, "R6 empty update stays idle", int'(busy), 0);
    // R6 R12: position latched as 5 from the counter sum; slot 8
    sched(3, 8'h11);
    check(int'(pending) == 1, "R5 schedule increments", int'(pending), 1);
    update(7);
    drained("R2 early update leaves event", 1);
    expectFire(8'h11, "R12 R2 fire at summed time");
    update(8);
    drained("R2 fired and counted down", 0);

    // R4: three in slot 10, newest first
    sched(2, 8'hA1); sched(2, 8'hA2); sched(2, 8'hA3);
    check(int'(pending) == 3, "R5 three stored", int'(pending), 3);
    expectFire(8'hA3, "R4 lifo first");
    expectFire(8'hA2, "R4 lifo second");
    expectFire(8'hA1, "R4 lifo third");
    update(10);
    drained("R4 slot emptied", 0);

    // R8: slots 15, 11, 13 come out in walk order
    sched(5, 8'hB1); sched(1, 8'hB2); sched(3, 8'hB3);
    expectFire(8'hB2, "R8 slot 11");
    expectFire(8'hB3, "R8 slot 13");
    expectFire(8'hB1, "R8 slot 15");
    update(15);
    drained("R8 all passed slots drained", 0);

    // R7: wrap from 15 to 3
    sched(3, 8'hC1); sched(14, 8'hC2); sched(1, 8'hC3);
    expectFire(8'hC3, "R7 slot 0 after wrap");
    expectFire(8'hC1, "R7 slot 2 after wrap");
    update(19);
    drained("R7 slot 13 still pending", 1);
    expectFire(8'hC2, "R7 slot 13 later");
    update(29);
    drained("R7 second walk", 0);

    // R13: same position after a full lap fires nothing
    sched(4, 8'hD1);
    update(45);
    drained("R13 same slot no fire", 1);
    expectFire(8'hD1, "R13 fires on real move");
    update(49);
    drained("R13 follow-up", 0);

    // R3: fifth entry into slot 3 is dropped
    for (int k = 1; k <= 4; k++) sched(2, 8'hE0 + k);
    check(!overflow, "R3 no overflow when room", int'(overflow), 0);
    sched(2, 8'hEF);
    check(overflow, "R3 overflow pulse", int'(overflow), 1);
    check(int'(pending) == 4, "R3 count unchanged", int'(pending), 4);
    @(negedge clk);
    check(!overflow, "R3 pulse is one cycle", int'(overflow), 0);
    for (int k = 4; k >= 1; k--) expectFire(8'hE0 + k, "R3 kept entries");
    update(51);
    drained("R3 dropped entry absent", 0);

    // R11: delay zero ignored
    sched(0, 8'hF0);
    check(int'(pending) == 0, "R11 zero delay not stored", int'(pending), 0);
    sched(1, 8'hF1);
    expectFire(8'hF1, "R11 only the valid event");
    update(52);
    drained("R11 after update", 0);

    // R10: inputs ignored during a walk
    sched(1, 8'h61); sched(6, 8'h62);
    expectFire(8'h61, "R10 walk slot 5");
    expectFire(8'h62, "R10 walk slot 10");
    @(negedge clk);
    setTime(60);
    updateValid = 1'b1;
    @(negedge clk);
    updateValid = 1'b0;
    check(busy, "R10 walk running", int'(busy), 1);
    setTime(70);
    schedValid = 1'b1; schedDelay = IDX_W'(1); schedId = 8'h99;
    updateValid = 1'b1;
    @(negedge clk);
    schedValid = 1'b0; updateValid = 1'b0;
    setTime(60);
    waitIdle();
    drained("R10 busy inputs dropped", 0);

    // R14: combined schedule and update, placed from old position 12
    sched(2, 8'h71);
    expectFire(8'h71, "R14 slot 14");
    expectFire(8'h72, "R14 slot 15 from old position");
    @(negedge clk);
    schedValid = 1'b1; schedDelay = IDX_W'(3); schedId = 8'h72;
    setTime(63);
    updateValid = 1'b1;
    @(negedge clk);
    schedValid = 1'b0; updateValid = 1'b0;
    waitIdle();
    drained("R14 both fired", 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9 scoreboard empty", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule